// File: doc/BRIEF.md
# Double-Buffered Transmit Endpoint Packet Buffer

This block holds outgoing packets for one transmit endpoint of a USB device controller. Firmware pushes bytes one at a time into the slot being loaded. It then writes a control word whose commit bit closes that slot as a queued packet. The number of bytes written before the commit becomes the packet length, and a commit with no bytes queues a zero-length packet. A serializer on the other side sees the oldest queued packet. It pulls the bytes in order, with a marker on the final byte, and reports completion with a one-cycle sent pulse, which frees the slot.

Two slots exist, and an input selects whether both are used or only one. Firmware can read a status byte. Bit 1 of that byte shows whether anything is queued, and bit 0 shows whether every enabled slot is taken. A flush bit in the same word throws away one whole queued packet per write. With both slots in use, firmware therefore flushes, checks the queued flag, and flushes again if the flag is still set. A packet that the serializer has already started on is never flushed. Loads and commits attempted with no free slot are dropped and raise a sticky overrun flag.

Top module: `usb_tx_ep_fifo`

## Requirements
- R1: After reset no packet is queued: `csr_rd_data` reads 0x00 and `tx_pkt_valid` is 0.
- R2: Accepted data bytes are stored in write order. A control write with bit 0 = 1 queues the loaded bytes as one packet. `tx_len` then equals the byte count, `tx_data` shows the byte at the current read position, each `tx_rd` advances that position, and `tx_last` is 1 only while the final byte is shown.
- R3: A commit with no bytes loaded queues a packet with `tx_len` = 0 and `tx_last` = 0. This packet still needs a `tx_sent` to leave the queue.
- R4: Read bit 1 is 1 exactly when at least one packet is queued. Read bit 0 is 1 exactly when all enabled slots hold queued packets.
- R5: Packets leave in commit order. A `tx_sent` pulse removes the oldest packet, and the next one becomes visible on the following cycle.
- R6: A control write with bit 3 = 1 removes exactly one packet, the oldest one that is not in flight. Bit 3 always reads 0.
- R7: With `dbl_buf_en` = 1 and two packets queued, one flush leaves the newer packet (read value 0x02). A second flush empties the queue.
- R8: With `dbl_buf_en` = 0 only one packet can be queued. Read bits 0 and 1 are then equal, and a single flush empties the queue.
- R9: A packet is in flight once `tx_rd` has been seen for it, or while `tx_sent` is high. A flush then removes the newer queued packet, or has no effect if there is none.
- R10: With no free slot, data bytes and commits are dropped. A 65th byte into one slot is also dropped. Each drop sets read bit 2, which stays set until a control write with bit 2 = 1 clears it.
- R11: A control write with both bit 3 and bit 0 set performs the flush and ignores the commit.
- R12: If `tx_sent` and a flush land in the same cycle while two packets are queued and the older one is in flight, both packets are gone afterwards and the queue works normally from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbl_buf_en | input | 1 | 1 = two slots, 0 = one slot; change only while empty |
| wr_valid | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte for the slot being loaded |
| csr_wr_en | input | 1 | Control word write strobe |
| csr_wr_data | input | 8 | Control word: bit0 commit, bit2 clear overrun, bit3 flush |
| csr_rd_data | output | 8 | Status: bit0 no free slot, bit1 queued, bit2 overrun, bit3 reads 0 |
| tx_pkt_valid | output | 1 | Oldest packet available |
| tx_len | output | 7 | Length in bytes of the oldest packet |
| tx_data | output | 8 | Byte at the current read position |
| tx_last | output | 1 | Current byte is the final byte of the packet |
| tx_rd | input | 1 | Serializer takes the current byte |
| tx_sent | input | 1 | Serializer finished the oldest packet |

## Verification
A flush can land in the same cycle in which the serializer either takes its first byte or reports a packet as sent. The block must then decide whether the flush hits the packet in flight or the one queued behind it. The bench builds a two-packet queue, pulses `tx_rd` once, and then issues a flush alone or together with `tx_sent`. After each case it judges the result from the status byte, from `tx_len` and from the bytes still streamed out. A separate case commits at the moment the queue is full, and the bench checks through the overrun bit and the contents of the next packet that nothing was written.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;

    localparam int SLOTS      = 2;
    localparam int SLOT_BYTES = 64;

    // control/status bit positions (firmware-visible)
    localparam int B_READY  = 0;
    localparam int B_NEMPTY = 1;
    localparam int B_OVR    = 2;
    localparam int B_FLUSH  = 3;

    typedef logic slot_id_t;

    typedef struct packed {
        logic [3:0] spare;
        logic       flush;
        logic       overrun;
        logic       not_empty;
        logic       ready;
    } ep_csr_t;

    function automatic slot_id_t next_slot(slot_id_t s, logic dbl);
        return dbl ? ~s : 1'b0;
    endfunction

    function automatic logic [1:0] slot_cap(logic dbl);
        return dbl ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/txf_slot_store.sv
module txf_slot_store
    import txfifo_pkg::*;
#(
    parameter int DEPTH = SLOT_BYTES,
    parameter int W     = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  slot_id_t      w_slot,
    input  logic [IW-1:0] w_idx,
    input  logic [W-1:0]  w_data,
    input  slot_id_t      r_slot,
    input  logic [IW-1:0] r_idx,
    output logic [W-1:0]  r_data
);

    logic [W-1:0] bank_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_bank
        logic [W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && w_slot == slot_id_t'(s)) begin
                cells[w_idx] <= w_data;
            end
        end

        assign bank_q[s] = cells[r_idx];
    end

    assign r_data = bank_q[r_slot];

endmodule

// File: rtl/txf_queue_ctrl.sv
module txf_queue_ctrl
    import txfifo_pkg::*;
#(
    parameter int DEPTH = SLOT_BYTES,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbl_en,
    input  logic          wr_valid,
    input  logic          commit_req,
    input  logic          flush_req,
    input  logic          tx_rd,
    input  logic          tx_sent,
    output logic          wr_accept,
    output slot_id_t      wr_slot,
    output logic [IW-1:0] wr_idx,
    output slot_id_t      rd_slot,
    output logic [LW-1:0] rd_cnt,
    output logic [LW-1:0] head_len,
    output logic [1:0]    q_cnt,
    output logic          is_full,
    output logic          overrun_evt
);

    logic [LW-1:0] fill [SLOTS];
    slot_id_t      wptr, rptr, tail_slot;
    logic [1:0]    qcnt;
    logic [LW-1:0] rcnt;
    logic          busy;
    logic          full, eff_busy, pop_head, drop_tail, push;

    always_comb begin
        full        = qcnt >= slot_cap(dbl_en);
        wr_accept   = wr_valid && !full && (fill[wptr] != LW'(DEPTH));
        push        = commit_req && !full;
        eff_busy    = busy || tx_sent || (tx_rd && qcnt != 2'd0);
        pop_head    = (qcnt != 2'd0) && (tx_sent || (flush_req && !eff_busy));
        drop_tail   = flush_req && eff_busy && (qcnt == 2'd2);
        tail_slot   = next_slot(rptr, dbl_en);
        overrun_evt = (wr_valid && !wr_accept) || (commit_req && full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= 1'b0;
            rptr <= 1'b0;
            qcnt <= 2'd0;
            rcnt <= '0;
            busy <= 1'b0;
        end else begin
            qcnt <= qcnt + {1'b0, push} - {1'b0, pop_head} - {1'b0, drop_tail};
            if (pop_head) begin
                rptr <= next_slot(rptr, dbl_en);
                rcnt <= '0;
                busy <= 1'b0;
            end else if (tx_rd && qcnt != 2'd0) begin
                busy <= 1'b1;
                if (rcnt < fill[rptr]) begin
                    rcnt <= rcnt + LW'(1);
                end
            end
            if (drop_tail) begin
                wptr <= tail_slot;
            end else if (push) begin
                wptr <= next_slot(wptr, dbl_en);
            end
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_fill
        logic clr;
        assign clr = (pop_head && rptr == slot_id_t'(s)) ||
                     (drop_tail && tail_slot == slot_id_t'(s));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                fill[s] <= '0;
            end else if (wr_accept && wptr == slot_id_t'(s)) begin
                fill[s] <= fill[s] + LW'(1);
            end
        end
    end

    assign wr_slot  = wptr;
    assign wr_idx   = fill[wptr][IW-1:0];
    assign rd_slot  = rptr;
    assign rd_cnt   = rcnt;
    assign head_len = fill[rptr];
    assign q_cnt    = qcnt;
    assign is_full  = full;

endmodule

// File: rtl/txf_csr.sv
module txf_csr
    import txfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] q_cnt,
    input  logic       is_full,
    input  logic       overrun_evt,
    output logic       commit_req,
    output logic       flush_req,
    output logic [7:0] rd_data
);

    logic    ovr;
    ep_csr_t view;
    logic    sig_unused;

    assign sig_unused = ^{wr_data[7:4], wr_data[B_NEMPTY]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr <= 1'b0;
        end else if (overrun_evt) begin
            ovr <= 1'b1;
        end else if (wr_en && wr_data[B_OVR]) begin
            ovr <= 1'b0;
        end
    end

    always_comb begin
        commit_req     = wr_en && wr_data[B_READY] && !wr_data[B_FLUSH];
        flush_req      = wr_en && wr_data[B_FLUSH];
        view           = '0;
        view.ready     = is_full;
        view.not_empty = (q_cnt != 2'd0);
        view.overrun   = ovr;
        rd_data        = view;
    end

endmodule

// File: rtl/usb_tx_ep_fifo.sv
module usb_tx_ep_fifo
    import txfifo_pkg::*;
#(
    parameter int DEPTH = SLOT_BYTES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       dbl_buf_en,
    input  logic                       wr_valid,
    input  logic [7:0]                 wr_data,
    input  logic                       csr_wr_en,
    input  logic [7:0]                 csr_wr_data,
    output logic [7:0]                 csr_rd_data,
    output logic                       tx_pkt_valid,
    output logic [$clog2(DEPTH+1)-1:0] tx_len,
    output logic [7:0]                 tx_data,
    output logic                       tx_last,
    input  logic                       tx_rd,
    input  logic                       tx_sent
);

    localparam int LW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic          commit_req, flush_req, wr_accept, is_full, overrun_evt;
    slot_id_t      wr_slot, rd_slot;
    logic [IW-1:0] wr_idx;
    logic [LW-1:0] rd_cnt, head_len;
    logic [1:0]    q_cnt;

    txf_csr u_csr (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (csr_wr_en),
        .wr_data     (csr_wr_data),
        .q_cnt       (q_cnt),
        .is_full     (is_full),
        .overrun_evt (overrun_evt),
        .commit_req  (commit_req),
        .flush_req   (flush_req),
        .rd_data     (csr_rd_data)
    );

    txf_queue_ctrl #(.DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst         (rst),
        .dbl_en      (dbl_buf_en),
        .wr_valid    (wr_valid),
        .commit_req  (commit_req),
        .flush_req   (flush_req),
        .tx_rd       (tx_rd),
        .tx_sent     (tx_sent),
        .wr_accept   (wr_accept),
        .wr_slot     (wr_slot),
        .wr_idx      (wr_idx),
        .rd_slot     (rd_slot),
        .rd_cnt      (rd_cnt),
        .head_len    (head_len),
        .q_cnt       (q_cnt),
        .is_full     (is_full),
        .overrun_evt (overrun_evt)
    );

    txf_slot_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk    (clk),
        .we     (wr_accept),
        .w_slot (wr_slot),
        .w_idx  (wr_idx),
        .w_data (wr_data),
        .r_slot (rd_slot),
        .r_idx  (rd_cnt[IW-1:0]),
        .r_data (tx_data)
    );

    assign tx_pkt_valid = (q_cnt != 2'd0);
    assign tx_len       = head_len;
    assign tx_last      = tx_pkt_valid && (head_len != '0) &&
                          (rd_cnt + LW'(1) == head_len);

endmodule

// File: rtl/usb_tx_ep_fifo_chk.sv
module usb_tx_ep_fifo_chk #(
    parameter int DEPTH = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       dbl_buf_en,
    input logic                       csr_wr_en,
    input logic [7:0]                 csr_wr_data,
    input logic [7:0]                 csr_rd_data,
    input logic                       tx_pkt_valid,
    input logic [$clog2(DEPTH+1)-1:0] tx_len,
    input logic                       tx_last,
    input logic                       tx_sent
);

    logic sig_unused;
    assign sig_unused = ^{csr_wr_data[7:4], csr_wr_data[1:0], csr_rd_data[7:3]};

    // R4: queued flag agrees with the packet-valid output
    a_r4_nempty_tracks_valid: assert property (@(posedge clk) disable iff (rst)
        csr_rd_data[1] == tx_pkt_valid);

    // R8: with one slot, "no free slot" equals "something queued"
    a_r8_single_ready_eq_nempty: assert property (@(posedge clk) disable iff (rst)
        !dbl_buf_en |-> (csr_rd_data[0] == csr_rd_data[1]));

    // R2: last-byte marker only on a non-empty valid packet
    a_r2_last_needs_len: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> (tx_pkt_valid && tx_len != '0));

    // R2: length never exceeds a slot
    a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
        32'(tx_len) <= DEPTH);

    // R5: a send without a control write leaves a free slot
    a_r5_sent_frees: assert property (@(posedge clk) disable iff (rst)
        (tx_sent && tx_pkt_valid && !csr_wr_en) |=> !csr_rd_data[0]);

    // R10: overrun stays set until cleared by a write
    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (csr_rd_data[2] && !(csr_wr_en && csr_wr_data[2])) |=> csr_rd_data[2]);

    // R10: a full queue stays full without a send or a flush
    a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
        (csr_rd_data[0] && !tx_sent && !(csr_wr_en && csr_wr_data[3]))
        |=> csr_rd_data[0]);

endmodule

bind usb_tx_ep_fifo usb_tx_ep_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dbl_buf_en   (dbl_buf_en),
    .csr_wr_en    (csr_wr_en),
    .csr_wr_data  (csr_wr_data),
    .csr_rd_data  (csr_rd_data),
    .tx_pkt_valid (tx_pkt_valid),
    .tx_len       (tx_len),
    .tx_last      (tx_last),
    .tx_sent      (tx_sent)
);

// File: tb/tb_usb_tx_ep_fifo.sv
module tb_usb_tx_ep_fifo;

    logic       clk = 1'b0;
    logic       rst, dbl_buf_en, wr_valid, csr_wr_en, tx_rd, tx_sent;
    logic [7:0] wr_data, csr_wr_data, csr_rd_data, tx_data;
    logic       tx_pkt_valid, tx_last;
    logic [6:0] tx_len;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    usb_tx_ep_fifo dut (
        .clk(clk), .rst(rst), .dbl_buf_en(dbl_buf_en),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
        .tx_pkt_valid(tx_pkt_valid), .tx_len(tx_len), .tx_data(tx_data),
        .tx_last(tx_last), .tx_rd(tx_rd), .tx_sent(tx_sent)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(logic [7:0] b);
        wr_valid = 1'b1; wr_data = b; tick(); wr_valid = 1'b0;
    endtask

    task automatic csr(logic [7:0] v);
        csr_wr_en = 1'b1; csr_wr_data = v; tick(); csr_wr_en = 1'b0;
    endtask

    task automatic load(int len, logic [7:0] base);
        for (int i = 0; i < len; i++) put_byte(base + 8'(i));
    endtask

    task automatic pulse_rd();
        tx_rd = 1'b1; tick(); tx_rd = 1'b0;
    endtask

    task automatic pulse_sent();
        tx_sent = 1'b1; tick(); tx_sent = 1'b0;
    endtask

    // R2/R3/R5: stream one packet out from its first byte
    task automatic drain(string tag, int len, logic [7:0] base);
        expect8({tag, " R5 valid"}, {7'd0, tx_pkt_valid}, 8'd1);
        expect8({tag, " R2 len"}, {1'b0, tx_len}, 8'(len));
        if (len == 0) expect8({tag, " R3 zlp last"}, {7'd0, tx_last}, 8'd0);
        for (int i = 0; i < len; i++) begin
            expect8({tag, " R2 data"}, tx_data, base + 8'(i));
            expect8({tag, " R2 last"}, {7'd0, tx_last}, {7'd0, i == len - 1});
            pulse_rd();
        end
        pulse_sent();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lens[4] = '{0, 1, 3, 64};
        rst = 1'b1; dbl_buf_en = 1'b1; wr_valid = 1'b0; wr_data = '0;
        csr_wr_en = 1'b0; csr_wr_data = '0; tx_rd = 1'b0; tx_sent = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        expect8("R1 reset csr", csr_rd_data, 8'h00);
        expect8("R1 reset valid", {7'd0, tx_pkt_valid}, 8'd0);

        // R2 R3 R4 R5: pairs of packet lengths in double mode
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [7:0] ba, bb;
                ba = 8'(a * 40 + b * 7 + 1);
                bb = ba + 8'd100;
                load(lens[a], ba); csr(8'h01);
                expect8("R4 one queued", csr_rd_data, 8'h02);
                load(lens[b], bb); csr(8'h01);
                expect8("R4 both queued", csr_rd_data, 8'h03);
                drain("R5 first", lens[a], ba);
                expect8("R5 one left", csr_rd_data, 8'h02);
                drain("R5 second", lens[b], bb);
                expect8("R5 empty", csr_rd_data, 8'h00);
            end
        end

        // R10: 65th byte dropped
        load(65, 8'h00);
        expect8("R10 byte overrun", csr_rd_data, 8'h04);
        csr(8'h01);
        expect8("R10 commit after overrun", csr_rd_data, 8'h06);
        csr(8'h04);
        expect8("R10 clear overrun", csr_rd_data, 8'h02);
        drain("R10 full slot", 64, 8'h00);

        // R10: writes while full are dropped
        load(2, 8'd10); csr(8'h01);
        load(3, 8'd20); csr(8'h01);
        put_byte(8'd99); csr(8'h01);
        expect8("R10 full drop", csr_rd_data, 8'h07);
        expect8("R10 head len kept", {1'b0, tx_len}, 8'd2);
        csr(8'h04);
        expect8("R10 cleared", csr_rd_data, 8'h03);
        drain("R10 a", 2, 8'd10);
        drain("R10 b", 3, 8'd20);
        csr(8'h01);
        drain("R10 no stray byte", 0, 8'd0);
        expect8("R10 end", csr_rd_data, 8'h00);

        // R6 R7: two flushes empty the double buffer
        load(2, 8'd30); csr(8'h01);
        load(3, 8'd40); csr(8'h01);
        csr(8'h08);
        expect8("R7 first flush", csr_rd_data, 8'h02);
        expect8("R6 oldest removed len", {1'b0, tx_len}, 8'd3);
        expect8("R6 oldest removed data", tx_data, 8'd40);
        csr(8'h08);
        expect8("R7 second flush", csr_rd_data, 8'h00);
        csr(8'h08);
        expect8("R6 flush on empty", csr_rd_data, 8'h00);

        // R8: single slot
        dbl_buf_en = 1'b0;
        load(2, 8'd50); csr(8'h01);
        expect8("R8 single full", csr_rd_data, 8'h03);
        put_byte(8'd1); csr(8'h01);
        expect8("R8 second commit ignored", csr_rd_data, 8'h07);
        csr(8'h04);
        csr(8'h08);
        expect8("R8 one flush empties", csr_rd_data, 8'h00);
        load(1, 8'd60); csr(8'h01);
        drain("R8 after flush", 1, 8'd60);
        expect8("R8 end", csr_rd_data, 8'h00);
        dbl_buf_en = 1'b1;

        // R9: flush while head in flight hits the newer packet
        load(4, 8'd70); csr(8'h01);
        load(5, 8'd80); csr(8'h01);
        expect8("R9 head byte0", tx_data, 8'd70);
        pulse_rd();
        csr(8'h08);
        expect8("R9 tail flushed", csr_rd_data, 8'h02);
        expect8("R9 head len", {1'b0, tx_len}, 8'd4);
        for (int i = 1; i < 4; i++) begin
            expect8("R9 head data", tx_data, 8'd70 + 8'(i));
            pulse_rd();
        end
        pulse_sent();
        expect8("R9 end", csr_rd_data, 8'h00);
        load(2, 8'd90); csr(8'h01);
        pulse_rd();
        csr(8'h08);
        expect8("R9 flush ignored", csr_rd_data, 8'h02);
        expect8("R9 data intact", tx_data, 8'd91);
        pulse_rd();
        pulse_sent();
        expect8("R9 end2", csr_rd_data, 8'h00);

        // R11: flush with commit bit
        load(2, 8'd5); csr(8'h01);
        csr(8'h09);
        expect8("R11 flush wins", csr_rd_data, 8'h00);
        expect8("R11 no zlp", {7'd0, tx_pkt_valid}, 8'd0);

        // R12: sent and flush in the same cycle
        load(1, 8'd1); csr(8'h01);
        load(2, 8'd2); csr(8'h01);
        pulse_rd();
        tx_sent = 1'b1; csr_wr_en = 1'b1; csr_wr_data = 8'h08;
        tick();
        tx_sent = 1'b0; csr_wr_en = 1'b0;
        expect8("R12 both gone", csr_rd_data, 8'h00);
        load(3, 8'd7); csr(8'h01);
        drain("R12 after", 3, 8'd7);
        expect8("R12 end", csr_rd_data, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule